// File: doc/BRIEF.md
# ECC Memory Scrubber with Poison Tracking

This block sits between a requester and a single-port memory whose words are stored with a 39-bit single-error-correct, double-error-detect code over 32 data bits. Demand reads pass through the block. It checks each word it reads, returns corrected data to the requester, and repairs the stored copy in the same pass. A write is encoded and stored in one cycle.

When no request is pending, the block walks the memory on its own, one address per visit. Each patrol visit reads a word, and if the word holds a single-bit fault, the block writes back the corrected codeword. A word whose fault cannot be corrected is never rewritten. Its address is marked in a per-address poison tag that persists until a full write replaces the word. The block reports such a word on a one-cycle error strobe. When the patrol, not a requester, finds it, the block also raises a machine-check style event. Two saturating counters tally corrected and uncorrectable faults and are visible as outputs.

Top module: `ecc_scrubber`

## Requirements
- R1: A stored codeword uses Hamming positions 1..38 held at bit positions 1..38. The check bits sit at positions 1, 2, 4, 8, 16 and 32. Data bits 0..31 fill the remaining positions in ascending order. Each check bit makes the XOR of all positions whose index has that bit set equal to zero. Bit 0 holds even parity over bits 1..38.
- R2: A demand read accepted at a clock edge produces `rspValid` high for exactly the following cycle, carrying the stored data. The memory returns read data one cycle after `memEn` with `memWe` low.
- R3: When a demand read finds a single-bit fault, the response carries the corrected data, `errCorr` pulses, and the corrected codeword is written to the same address in the response cycle.
- R4: In every idle cycle without a request, the block issues a patrol read. Patrol reads visit addresses 0, 1, 2, … in ascending order, start at address 0 after reset, and wrap from the top address to 0. Each single-bit fault found by the patrol is repaired by a write-back.
- R5: A request presented in an idle cycle is accepted in preference to the patrol. `reqReady` is low while a read is being checked.
- R6: A word with a double-bit fault is not written back. Its address becomes poisoned, and a demand response for it has `rspPoison` high and `errUncorr` pulsing.
- R7: `patrolFatal` pulses for one cycle when a patrol read finds an uncorrectable fault in an unpoisoned word. A demand read that finds the same kind of fault does not raise it.
- R8: A read of a poisoned address, whether demand or patrol, causes no write-back and no counter change. A demand read of such an address returns `rspPoison` high.
- R9: A write stores the encoded data and clears that address's poison tag.
- R10: `corrCount` and `uncorrCount` increase by one for each newly found corrected or uncorrectable fault. Each holds at its all-ones value once it gets there.
- R11: After reset, both counters are zero, no address is poisoned, `rspValid` is low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | 32 | Write data |
| reqReady | output | 1 | Request accepted at this edge when high with reqValid |
| rspValid | output | 1 | Read response valid |
| rspData | output | 32 | Corrected read data |
| rspPoison | output | 1 | Response word is poisoned |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | 39 | Codeword to memory |
| memRdata | input | 39 | Codeword from memory, one cycle after a read |
| errCorr | output | 1 | Corrected fault found this cycle |
| errUncorr | output | 1 | Uncorrectable fault found this cycle |
| patrolFatal | output | 1 | Patrol found an uncorrectable fault |
| corrCount | output | CNT_W | Saturating corrected-fault count |
| uncorrCount | output | CNT_W | Saturating uncorrectable-fault count |

## Verification
The properties check several rules on every cycle. A response lasts a single cycle, and the ready signal is low while it is shown. A corrected fault always comes with a memory write, and an uncorrectable or poisoned word never does. The machine-check event appears only alongside an uncorrectable report outside any response. The counters never fall and stay pinned once full. Other behaviour can only be shown by the bench's scenarios, which inject faults into its memory model: the corrected data values, the exact codeword that is written back, the ascending and wrapping patrol order, poison persisting across later reads and being cleared by a write, and demand winning the race against the patrol for a freshly damaged word.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  localparam int DATA_W = 32;
  localparam int CODE_W = 39;

  // strobes from control to datapath
  typedef struct packed {
    logic issueRead;
    logic issueWrite;
    logic issuePatrol;
    logic writeBack;
    logic setPoison;
    logic bumpCorr;
    logic bumpUncorr;
    logic respond;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic singleErr;
    logic doubleErr;
    logic tagHit;
  } status_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              isSingle;
    logic              isDouble;
  } decode_t;

  function automatic logic [CODE_W-1:0] secdedEncode(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] w;
    logic [4:0]        j;
    logic              par;
    w = '0;
    j = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        w[6'(p)] = d[j];
        j = j + 5'd1;
      end
    end
    for (int k = 0; k < 6; k++) begin
      par = 1'b0;
      for (int p = 1; p < CODE_W; p++) begin
        if (((p >> k) & 1) == 1) par = par ^ w[6'(p)];
      end
      w[6'(1 << k)] = par;
    end
    w[0] = ^w[CODE_W-1:1];
    return w;
  endfunction

  function automatic decode_t secdedDecode(input logic [CODE_W-1:0] cw);
    decode_t           r;
    logic [5:0]        syn;
    logic [CODE_W-1:0] fixedWord;
    logic [4:0]        j;
    r = '0;
    syn = '0;
    j = '0;
    fixedWord = cw;
    for (int p = 1; p < CODE_W; p++) begin
      if (cw[6'(p)]) syn = syn ^ 6'(p);
    end
    if (^cw) begin
      if (int'(syn) < CODE_W) begin
        fixedWord[syn] = ~fixedWord[syn];
        r.isSingle = 1'b1;
      end else begin
        r.isDouble = 1'b1;
      end
    end else if (syn != '0) begin
      r.isDouble = 1'b1;
    end
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        r.data[j] = fixedWord[6'(p)];
        j = j + 5'd1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/scrub_datapath.sv
module scrub_datapath
  import scrub_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  output status_t           stat,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [CODE_W-1:0] memWdata,
  input  logic [CODE_W-1:0] memRdata,
  output logic [DATA_W-1:0] rspData,
  output logic [CNT_W-1:0]  corrCount,
  output logic [CNT_W-1:0]  uncorrCount
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] patrolPtr;
  logic [DEPTH-1:0]  poisonTag;
  decode_t           dec;

  assign dec = secdedDecode(memRdata);

  always_comb begin
    stat.singleErr = dec.isSingle;
    stat.doubleErr = dec.isDouble;
    stat.tagHit    = poisonTag[curAddr];
  end

  assign rspData = strb.respond ? dec.data : '0;

  // memory port steering
  always_comb begin
    memEn    = strb.issueRead | strb.issueWrite | strb.issuePatrol | strb.writeBack;
    memWe    = strb.issueWrite | strb.writeBack;
    memWdata = secdedEncode(strb.issueWrite ? reqWdata : dec.data);
    if (strb.issueRead || strb.issueWrite) memAddr = reqAddr;
    else if (strb.issuePatrol)             memAddr = patrolPtr;
    else                                   memAddr = curAddr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr   <= '0;
      patrolPtr <= '0;
      poisonTag <= '0;
    end else begin
      if (strb.issueRead) curAddr <= reqAddr;
      if (strb.issuePatrol) begin
        curAddr   <= patrolPtr;
        patrolPtr <= patrolPtr + 1'b1;
      end
      if (strb.issueWrite) poisonTag[reqAddr] <= 1'b0;
      if (strb.setPoison)  poisonTag[curAddr] <= 1'b1;
    end
  end

  // two saturating fault counters
  logic [1:0]       bump;
  logic [CNT_W-1:0] cntQ [2];
  assign bump = {strb.bumpUncorr, strb.bumpCorr};

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)                              cntQ[i] <= '0;
      else if (bump[i] && cntQ[i] != '1)    cntQ[i] <= cntQ[i] + 1'b1;
    end
  end

  assign corrCount   = cntQ[0];
  assign uncorrCount = cntQ[1];

endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  status_t stat,
  output strobe_t strb,
  output logic    reqReady,
  output logic    patrolFatal
);

  typedef enum logic {ST_IDLE, ST_CHECK} state_t;

  state_t state;
  logic   curDemand;
  logic   idle;

  assign idle     = (state == ST_IDLE);
  assign reqReady = idle;

  always_comb begin
    strb = '0;
    if (idle) begin
      if (reqValid) begin
        strb.issueWrite = reqWrite;
        strb.issueRead  = ~reqWrite;
      end else begin
        strb.issuePatrol = 1'b1;
      end
    end else begin
      strb.respond = curDemand;
      if (!stat.tagHit) begin
        if (stat.singleErr) begin
          strb.writeBack = 1'b1;
          strb.bumpCorr  = 1'b1;
        end else if (stat.doubleErr) begin
          strb.setPoison  = 1'b1;
          strb.bumpUncorr = 1'b1;
        end
      end
    end
  end

  assign patrolFatal = ~idle & ~curDemand & ~stat.tagHit & stat.doubleErr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      curDemand <= 1'b0;
    end else begin
      if (idle) begin
        if (strb.issueRead || strb.issuePatrol) state <= ST_CHECK;
        curDemand <= strb.issueRead;
      end else begin
        state <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/ecc_scrubber.sv
module ecc_scrubber
  import scrub_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic              rspPoison,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [38:0]       memWdata,
  input  logic [38:0]       memRdata,
  output logic              errCorr,
  output logic              errUncorr,
  output logic              patrolFatal,
  output logic [CNT_W-1:0]  corrCount,
  output logic [CNT_W-1:0]  uncorrCount
);

  strobe_t strb;
  status_t stat;

  scrub_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .stat       (stat),
    .strb       (strb),
    .reqReady   (reqReady),
    .patrolFatal(patrolFatal)
  );

  scrub_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .stat       (stat),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .rspData    (rspData),
    .corrCount  (corrCount),
    .uncorrCount(uncorrCount)
  );

  assign rspValid  = strb.respond;
  assign rspPoison = strb.respond & (stat.tagHit | stat.doubleErr);
  assign errCorr   = strb.bumpCorr;
  assign errUncorr = strb.bumpUncorr;

endmodule

// File: rtl/scrub_checker.sv
module scrub_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             reqReady,
  input logic             rspValid,
  input logic             rspPoison,
  input logic             memEn,
  input logic             memWe,
  input logic             errCorr,
  input logic             errUncorr,
  input logic             patrolFatal,
  input logic [CNT_W-1:0] corrCount,
  input logic [CNT_W-1:0] uncorrCount
);

  AST_RSP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid); // R2

  AST_CORR_WRITES_BACK: assert property (@(posedge clk) disable iff (rst)
    errCorr |-> (memEn && memWe)); // R3

  AST_BUSY_DURING_RSP: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> !reqReady); // R5

  AST_NO_WB_UNCORR: assert property (@(posedge clk) disable iff (rst)
    errUncorr |-> !memWe); // R6

  AST_FATAL_FROM_PATROL: assert property (@(posedge clk) disable iff (rst)
    patrolFatal |-> (errUncorr && !rspValid)); // R7

  AST_POISON_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspPoison) |-> !memWe); // R8

  AST_CORR_CNT_MONO: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (corrCount >= $past(corrCount))); // R10

  AST_UNCORR_CNT_MONO: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (uncorrCount >= $past(uncorrCount))); // R10

  AST_CORR_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (corrCount == '1) |=> (corrCount == '1)); // R10

  AST_UNCORR_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (uncorrCount == '1) |=> (uncorrCount == '1)); // R10

endmodule

bind ecc_scrubber scrub_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reqReady   (reqReady),
  .rspValid   (rspValid),
  .rspPoison  (rspPoison),
  .memEn      (memEn),
  .memWe      (memWe),
  .errCorr    (errCorr),
  .errUncorr  (errUncorr),
  .patrolFatal(patrolFatal),
  .corrCount  (corrCount),
  .uncorrCount(uncorrCount)
);

// File: tb/ecc_scrubber_test.sv
module ecc_scrubber_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 4;
  localparam int CW         = 4;
  localparam int DEPTH      = 1 << AW;
  localparam int CMAX       = (1 << CW) - 1;
  localparam int WATCHDOG   = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqWdata = '0;
  logic          reqReady, rspValid, rspPoison;
  logic [31:0]   rspData;
  logic          memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [38:0]   memWdata;
  logic [38:0]   memRdata = '0;
  logic          errCorr, errUncorr, patrolFatal;
  logic [CW-1:0] corrCount, uncorrCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_scrubber #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData), .rspPoison(rspPoison),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .errCorr(errCorr), .errUncorr(errUncorr),
    .patrolFatal(patrolFatal), .corrCount(corrCount), .uncorrCount(uncorrCount)
  );

  // memory model with fault injection and preload
  logic [38:0]   mem [DEPTH];
  logic          injEn = 1'b0, loadEn = 1'b0;
  logic [AW-1:0] injAddr = '0, loadAddr = '0;
  logic [38:0]   injMask = '0, loadWord = '0;

  always @(posedge clk) begin
    if (memEn && memWe)  mem[memAddr] <= memWdata;
    else if (memEn)      memRdata <= mem[memAddr];
    if (injEn)  mem[injAddr]  <= mem[injAddr] ^ injMask;
    if (loadEn) mem[loadAddr] <= loadWord;
  end

  int          vectors = 0, miscompares = 0, cycleCount = 0, fatalSeen = 0;
  int          expCorr = 0, expUncorr = 0, expFatal = 0;
  logic [31:0] golden [DEPTH];
  bit          expPoison [DEPTH];

  always @(negedge clk) begin
    if (!rst && patrolFatal) fatalSeen++;
    cycleCount++;
    if (cycleCount > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycleCount, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic logic [38:0] benchEncode(input logic [31:0] d);
    logic [38:0] w;
    logic [5:0]  s;
    int          k;
    w = '0; s = '0; k = 0;
    for (int p = 1; p < 39; p++) begin
      if ($countones(p) != 1) begin
        w[p] = d[k];
        if (d[k]) s = s ^ 6'(p);
        k++;
      end
    end
    for (int b = 0; b < 6; b++) w[1 << b] = s[b];
    w[0] = ^w[38:1];
    return w;
  endfunction

  function automatic int satInc(input int v);
    return (v < CMAX) ? v + 1 : v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [31:0] d);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    golden[a] = d;
    expPoison[a] = 1'b0;
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [31:0] d, output logic p);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 response valid one cycle after accept", 64'(rspValid), 64'(1));
    check("R5 ready low while checking", 64'(reqReady), 64'(0));
    d = rspData;
    p = rspPoison;
  endtask

  task automatic readCheck(input logic [AW-1:0] a, input string req);
    logic [31:0] d;
    logic        p;
    doRead(a, d, p);
    if (expPoison[a]) begin
      check({req, " poison flag"}, 64'(p), 64'(1));
    end else begin
      check({req, " data"}, 64'(d), 64'(golden[a]));
      check({req, " no poison"}, 64'(p), 64'(0));
    end
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [38:0] m);
    injEn = 1'b1; injAddr = a; injMask = m;
    @(negedge clk);
    injEn = 1'b0;
  endtask

  function automatic logic [38:0] oneBit(input int pos);
    return 39'(1) << pos;
  endfunction

  function automatic logic [38:0] twoBits();
    int a, b;
    a = $urandom_range(38);
    b = (a + 1 + $urandom_range(37)) % 39;
    return oneBit(a) | oneBit(b);
  endfunction

  task automatic countCheck(input string req);
    check({req, " corrected count"}, 64'(corrCount), 64'(expCorr));
    check({req, " uncorrectable count"}, 64'(uncorrCount), 64'(expUncorr));
  endtask

  task automatic singleDemand(input logic [AW-1:0] a, input logic [38:0] m, input string req);
    if (expPoison[a]) doWrite(a, $urandom);
    inject(a, m);
    readCheck(a, req);
    @(negedge clk);
    check({req, " repaired word"}, 64'(mem[a]), 64'(benchEncode(golden[a])));
    expCorr = satInc(expCorr);
    countCheck(req);
  endtask

  task automatic doubleDemand(input logic [AW-1:0] a, input string req);
    logic [38:0] bad;
    logic [38:0] m;
    if (expPoison[a]) doWrite(a, $urandom);
    m = twoBits();
    bad = benchEncode(golden[a]) ^ m;
    inject(a, m);
    expPoison[a] = 1'b1;
    readCheck(a, req);
    @(negedge clk);
    check({req, " no write-back"}, 64'(mem[a]), 64'(bad));
    expUncorr = satInc(expUncorr);
    countCheck(req);
  endtask

  initial begin
    logic [31:0] nd;
    void'($urandom(32'd20240611));
    // preload memory while in reset
    for (int i = 0; i < DEPTH; i++) begin
      golden[i] = $urandom;
      expPoison[i] = 1'b0;
      @(negedge clk);
      loadEn = 1'b1; loadAddr = AW'(i); loadWord = benchEncode(golden[i]);
    end
    @(negedge clk);
    loadEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // R11 reset state, R4 patrol start and order
    check("R11 rspValid low", 64'(rspValid), 64'(0));
    check("R11 reqReady high", 64'(reqReady), 64'(1));
    check("R11 counters zero", 64'({corrCount, uncorrCount}), 64'(0));
    check("R4 first patrol read", 64'({memEn, memWe, memAddr}), 64'({1'b1, 1'b0, AW'(0)}));
    @(negedge clk);
    check("R4 no access while checking", 64'(memEn), 64'(0));
    @(negedge clk);
    check("R4 next patrol address", 64'({memEn, memWe, memAddr}), 64'({1'b1, 1'b0, AW'(1)}));

    // R2 clean read
    readCheck(AW'(5), "R2 clean read");

    // R3 demand correction, including parity-bit and check-bit faults (R1)
    singleDemand(AW'(3), oneBit(7), "R3 data-bit fault");
    singleDemand(AW'(4), oneBit(0), "R1 overall parity fault");
    singleDemand(AW'(7), oneBit(32), "R1 check-bit fault");

    // R6 double fault on demand, R7 no event from demand
    doubleDemand(AW'(6), "R6 demand double fault");
    check("R7 no event on demand fault", 64'(fatalSeen), 64'(expFatal));

    // R8 re-read of poisoned word
    readCheck(AW'(6), "R8 poisoned re-read");
    @(negedge clk);
    countCheck("R8 counters unchanged");

    // R9 write clears poison, R1 encoding
    nd = $urandom;
    doWrite(AW'(6), nd);
    check("R1 stored codeword layout", 64'(mem[6]), 64'(benchEncode(nd)));
    readCheck(AW'(6), "R9 write clears poison");

    // R4 patrol repair at top address and after wrap
    inject(AW'(DEPTH-1), oneBit(19));
    repeat (4 * DEPTH) @(negedge clk);
    expCorr = satInc(expCorr);
    check("R4 patrol repaired top address", 64'(mem[DEPTH-1]), 64'(benchEncode(golden[DEPTH-1])));
    inject(AW'(0), oneBit(33));
    repeat (4 * DEPTH) @(negedge clk);
    expCorr = satInc(expCorr);
    check("R4 patrol repaired after wrap", 64'(mem[0]), 64'(benchEncode(golden[0])));
    countCheck("R4 patrol counts");

    // R7 patrol finds double fault
    inject(AW'(9), oneBit(3) | oneBit(25));
    repeat (4 * DEPTH) @(negedge clk);
    expFatal++;
    expUncorr = satInc(expUncorr);
    expPoison[9] = 1'b1;
    check("R7 patrol event pulses once", 64'(fatalSeen), 64'(expFatal));
    countCheck("R7 patrol uncorrectable count");
    readCheck(AW'(9), "R6 patrol-poisoned read");

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      logic [AW-1:0] a;
      int            op;
      a  = AW'($urandom_range(DEPTH - 1));
      op = $urandom_range(3);
      case (op)
        0: doWrite(a, $urandom);
        1: readCheck(a, "R2 random read");
        2: singleDemand(a, oneBit($urandom_range(38)), "R3 random single");
        default: doubleDemand(a, "R6 random double");
      endcase
    end
    check("R7 no event during demand traffic", 64'(fatalSeen), 64'(expFatal));

    // R10 saturation of both counters
    for (int it = 0; it < CMAX + 3; it++)
      singleDemand(AW'($urandom_range(DEPTH - 1)), oneBit($urandom_range(38)), "R10 corr saturation");
    for (int it = 0; it < CMAX + 3; it++)
      doubleDemand(AW'($urandom_range(DEPTH - 1)), "R10 uncorr saturation");
    check("R10 corrected count saturated", 64'(corrCount), 64'(CMAX));
    check("R10 uncorrectable count saturated", 64'(uncorrCount), 64'(CMAX));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule